// File: doc/BRIEF.md
# Relocatable Peripheral Register Window Decoder

This block sits on a simple 16-bit processor bus and decides, in every bus cycle, whether the access falls inside a window of on-chip peripheral control registers. The window holds 128 word registers and spans 256 byte addresses. It can lie either in memory space or in I/O space. The base of the window is not fixed. It comes from a relocation register that lives inside the window. Software moves the window by writing that register, and every later compare uses the newly programmed base.

On a hit, the block drives a 7-bit word-register index, a hit flag, and a read or write strobe toward the register file. The register file here is a small test bank used to exercise the decode. Every window transfer is a full 16-bit word. Byte address bit 0 takes no part in the decode. The external bus cycle still runs on every access, whether it hits the window or not, so the block reports a run flag for every cycle it sees.

The bus side uses plain control pins. A cycle is presented by holding `bus_cyc` high for one clock. The block decodes it combinationally in that same clock and never applies back-pressure, so no ready signal exists. After reset, the window base is FF00h in I/O space.

Top module: `periph_window`

## Requirements
- R1: After reset, with no bus cycle presented, `win_hit`, `reg_rd`, `reg_wr` and `ext_run` are 0 and `reg_idx` is 0.
- R2: After reset, an I/O-space access (`bus_mem`=0) with `bus_addr`[15:8]=FFh hits. `reg_idx` equals `bus_addr`[7:1].
- R3: The relocation register is word index 7Fh (byte offset FEh). It reads back as a 16-bit word holding the base byte in bits [7:0] and the space select in bit 12 (1 = memory space). All other bits read 0. Its reset value is 00FFh.
- R4: An access whose space differs from the programmed space, or whose `bus_addr`[15:8] differs from the programmed base, misses. On a miss `win_hit`=0, `reg_rd`=0, `reg_wr`=0 and `reg_idx`=0.
- R5: On a hit, `reg_rd` follows a read (`bus_we`=0) and `reg_wr` follows a write (`bus_we`=1). The two strobes are never high together.
- R6: Every transfer is a full word. A write at an odd byte address stores all 16 bits of `bus_wdata` in the register at index `bus_addr`[7:1]. That word reads back whole from either byte address of the pair.
- R7: A write to the relocation register takes effect from the next bus cycle. The writing cycle itself still decodes against the old base and space.
- R8: After relocation, the old base misses. The new base, in the new space, hits and reaches the same registers.
- R9: `ext_run` is 1 in every cycle with `bus_cyc`=1, for hits and misses alike.
- R10: A write that misses the window changes no window register. `win_rdata` is 0 whenever `reg_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cyc | input | 1 | A bus cycle is presented in this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_mem | input | 1 | 1 = memory space, 0 = I/O space |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data word |
| ext_run | output | 1 | External bus cycle runs this clock |
| win_hit | output | 1 | Access falls in the window |
| reg_idx | output | 7 | Selected word register, 0 on a miss |
| reg_rd | output | 1 | Read strobe toward the register file |
| reg_wr | output | 1 | Write strobe toward the register file |
| win_rdata | output | 16 | Read data from the selected register |

## Verification
Two functions can fall in the same clock: a write to the relocation register, and the decode of that very access. The write must be judged against the base it is about to replace. The bench provokes this by writing a new base and space through the window at the reset base. In that cycle it checks that the hit flag and write strobe are high under the old decode. In the following cycles it checks that the old address misses, that the new address in the new space hits, and that the relocation word and a test register read back through the new window.

// File: rtl/periph_window_pkg.sv
package periph_window_pkg;
  typedef struct packed {
    logic hit;
    logic rd;
    logic wr;
  } win_dec_t;
endpackage

// File: rtl/win_decode.sv
module win_decode #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 7,
  parameter int BASE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cyc,
  input  logic                         we,
  input  logic                         mem,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BASE_W-1:0]            base,
  input  logic                         base_mem,
  output periph_window_pkg::win_dec_t  dec,
  output logic [IDX_W-1:0]             idx
);
  logic match;

  assign match   = cyc && (mem == base_mem) && (addr[ADDR_W-1 -: BASE_W] == base);
  assign dec.hit = match;
  assign dec.rd  = match && !we;
  assign dec.wr  = match && we;
  assign idx     = match ? addr[IDX_W:1] : '0;

  assert_hit_needs_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc |-> !dec.hit && idx == '0);
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec.rd, dec.wr}));
endmodule

// File: rtl/win_reloc.sv
module win_reloc #(
  parameter int DATA_W    = 16,
  parameter int BASE_W    = 8,
  parameter int SPACE_BIT = 12,
  parameter logic [BASE_W-1:0] RST_BASE = '1,
  parameter logic RST_MEM   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [BASE_W-1:0] base,
  output logic              base_mem,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base     <= RST_BASE;
      base_mem <= RST_MEM;
    end else if (wr_en) begin
      base     <= wdata[BASE_W-1:0];
      base_mem <= wdata[SPACE_BIT];
    end
  end

  always_comb begin
    word             = '0;
    word[BASE_W-1:0] = base;
    word[SPACE_BIT]  = base_mem;
  end

  assert_reloc_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base == $past(wdata[BASE_W-1:0]) && base_mem == $past(wdata[SPACE_BIT]));
  assert_reloc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base) && $stable(base_mem));
endmodule

// File: rtl/win_test_bank.sv
module win_test_bank #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 7,
  parameter int NREGS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs [NREGS];
  logic [NREGS-1:0]  hit_vec;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    assign hit_vec[g] = (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                 regs[g] <= '0;
      else if (wr && hit_vec[g])  regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++)
      if (hit_vec[i]) rdata = regs[i];
  end
  assign sel = |hit_vec;

  assert_bank_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/periph_window.sv
module periph_window #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int REG_COUNT = 128,
  parameter int SPACE_BIT = 12,
  parameter int TEST_REGS = 4,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int BASE_W   = ADDR_W - IDX_W - 1,
  localparam logic [IDX_W-1:0] RELOC_IDX = IDX_W'(REG_COUNT - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cyc,
  input  logic              bus_we,
  input  logic              bus_mem,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              ext_run,
  output logic              win_hit,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] win_rdata
);
  import periph_window_pkg::*;

  win_dec_t          dec;
  logic [BASE_W-1:0] base;
  logic              base_mem;
  logic [DATA_W-1:0] reloc_word;
  logic [DATA_W-1:0] bank_rdata;
  logic              bank_sel;
  logic              reloc_sel;

  win_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cyc(bus_cyc), .we(bus_we), .mem(bus_mem),
    .addr(bus_addr), .base(base), .base_mem(base_mem), .dec(dec), .idx(reg_idx)
  );

  assign reloc_sel = (reg_idx == RELOC_IDX);

  win_reloc #(.DATA_W(DATA_W), .BASE_W(BASE_W), .SPACE_BIT(SPACE_BIT)) u_reloc (
    .clk(clk), .rst_n(rst_n), .wr_en(dec.wr && reloc_sel), .wdata(bus_wdata),
    .base(base), .base_mem(base_mem), .word(reloc_word)
  );

  win_test_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NREGS(TEST_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(dec.wr), .idx(reg_idx), .wdata(bus_wdata),
    .sel(bank_sel), .rdata(bank_rdata)
  );

  assign ext_run = bus_cyc;
  assign win_hit = dec.hit;
  assign reg_rd  = dec.rd;
  assign reg_wr  = dec.wr;

  always_comb begin
    win_rdata = '0;
    if (dec.rd) begin
      if (reloc_sel)     win_rdata = reloc_word;
      else if (bank_sel) win_rdata = bank_rdata;
    end
  end

  assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> !reg_rd && !reg_wr && win_rdata == '0);
  assert_hit_runs_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> ext_run);
  assert_strobe_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) |-> win_hit);
endmodule

// File: tb/periph_window_tb_top.sv
module periph_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cyc = 1'b0, bus_we = 1'b0, bus_mem = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic        ext_run, win_hit, reg_rd, reg_wr;
  logic [6:0]  reg_idx;
  logic [15:0] win_rdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  periph_window dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_mem(bus_mem),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ext_run(ext_run), .win_hit(win_hit),
    .reg_idx(reg_idx), .reg_rd(reg_rd), .reg_wr(reg_wr), .win_rdata(win_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // present one bus cycle at the falling edge; outputs settle before the next rising edge
  task automatic cyc(input logic we, input logic mem, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_cyc = 1'b1; bus_we = we; bus_mem = mem; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_cyc = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    #1;
  endtask

  task automatic t_reset();
    idle();
    chk("R1", "hit", win_hit, 0);
    chk("R1", "rd/wr", {reg_rd, reg_wr}, 0);
    chk("R1", "idx", reg_idx, 0);
    chk("R1", "ext_run", ext_run, 0);
  endtask

  task automatic t_reset_hit();
    cyc(0, 0, 16'hFFFE, 0);
    chk("R2", "hit", win_hit, 1);
    chk("R2", "idx", reg_idx, 7'h7F);
    chk("R5", "rd/wr on read", {reg_rd, reg_wr}, 2'b10);
    chk("R3", "reloc reset word", win_rdata, 16'h00FF);
    chk("R9", "ext_run hit", ext_run, 1);
    cyc(0, 0, 16'hFF25, 0);
    chk("R2", "idx odd addr", reg_idx, 7'h12);
  endtask

  task automatic t_misses();
    cyc(0, 1, 16'hFFFE, 0);
    chk("R4", "wrong space hit", win_hit, 0);
    chk("R4", "wrong space strobes/idx", {reg_rd, reg_wr, reg_idx}, 0);
    chk("R9", "ext_run miss", ext_run, 1);
    cyc(1, 0, 16'hFE02, 16'h1234);
    chk("R4", "wrong base hit", win_hit, 0);
    chk("R4", "wrong base strobes", {reg_rd, reg_wr}, 0);
    chk("R10", "rdata no read", win_rdata, 0);
  endtask

  task automatic t_word();
    cyc(1, 0, 16'hFF03, 16'hA5C3);
    chk("R5", "rd/wr on write", {reg_rd, reg_wr}, 2'b01);
    chk("R6", "idx odd write", reg_idx, 7'h01);
    cyc(0, 0, 16'hFF02, 0);
    chk("R6", "read even", win_rdata, 16'hA5C3);
    cyc(0, 0, 16'hFF03, 0);
    chk("R6", "read odd", win_rdata, 16'hA5C3);
  endtask

  task automatic t_relocate();
    cyc(1, 0, 16'hFFFE, 16'h1012);
    chk("R7", "write cycle old decode hit", win_hit, 1);
    chk("R7", "write cycle strobe", reg_wr, 1);
    cyc(0, 0, 16'hFFFE, 0);
    chk("R8", "old base miss", win_hit, 0);
    cyc(0, 1, 16'h12FE, 0);
    chk("R8", "new base hit", win_hit, 1);
    chk("R3", "reloc word", win_rdata, 16'h1012);
    cyc(0, 0, 16'h12FE, 0);
    chk("R8", "new base wrong space", win_hit, 0);
    cyc(0, 1, 16'h1202, 0);
    chk("R8", "test reg via new base", win_rdata, 16'hA5C3);
  endtask

  task automatic t_miss_write();
    cyc(1, 1, 16'h3402, 16'hDEAD);
    chk("R10", "miss write strobe", reg_wr, 0);
    cyc(1, 0, 16'hFF02, 16'hBEEF);
    chk("R10", "old base write strobe", reg_wr, 0);
    cyc(0, 1, 16'h1202, 0);
    chk("R10", "register unchanged", win_rdata, 16'hA5C3);
    idle();
    chk("R10", "rdata idle", win_rdata, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_reset_hit();
        t_misses();
        t_word();
        t_relocate();
        t_miss_write();
      end
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule